// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block prepares one active-low external interrupt pin for a microcontroller's interrupt controller. The raw pin first passes through a synchronizer. A small control register then decides two things: whether the pin reaches the interrupt logic at all, and whether a request comes from a low level on the pin or from a falling edge. In edge mode, a detected falling edge sets a pending latch. The latch holds the request until the interrupt is serviced or the block is reset.

Software writes the control register through a simple write strobe and can read it back at any time. The sensitivity select can be changed freely while the part runs in special mode. In normal or emulation mode it can be written only once after reset, so boot code can fix the pin's behaviour and later code cannot alter it. The enable bit stays writable in every mode. The interrupt controller sees one request line and returns a service-acknowledge pulse when it takes the interrupt.

Top module: `extint_pin_ctrl`

## Requirements
- R1: In level mode (select bit 7 = 0) with the enable set, `irq_req` is 1 exactly while the synchronized pin is low. It rises or falls two clock edges after the pin changes.
- R2: When the enable (bit 6) is 0, `irq_req` is 0 in both modes. The enable bit takes each written value in every mode.
- R3: With `special_mode` = 0, the first write after reset loads the select bit and locks it. Every later write leaves the select bit unchanged but still loads the enable bit. Writes made in special mode neither set nor clear the lock.
- R4: With `special_mode` = 1, every write loads the select bit.
- R5: In edge mode (select = 1), a synchronized 1-to-0 transition of the pin sets the pending latch, so `irq_req` rises on the third clock edge after the pin falls. The latch stays set after the pin returns high. It also captures edges that occur while the enable is 0.
- R6: A `svc_ack` pulse clears the pending latch on the next edge. If a new synchronized falling edge is present in the same cycle as the pulse, the latch stays set.
- R7: `rd_data` reads as {select, enable, 6'b000000}. Bits 5 to 0 read 0 and ignore written values.
- R8: After reset, `rd_data` = 8'h40 (select 0, enable 1), the lock is clear, the latch is clear and `irq_req` = 0.
- R9: Falling edges that occur while in level mode are not stored. Switching to edge mode afterwards gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special mode, 0 = normal or emulation mode |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| pin_n | input | 1 | Raw active-low interrupt pin |
| svc_ack | input | 1 | Interrupt serviced pulse |
| irq_req | output | 1 | Interrupt request to the controller |

## Verification
Each result has a fixed delay. A register write shows on `rd_data` after the edge that takes the write. A level-mode request follows the pin after two edges, and an edge-mode request rises after three. An acknowledge clears the request after one edge. The bench drives its inputs on the falling clock edge and steps a counted number of rising edges. It samples at the next falling edge, so each check falls exactly on the cycle the result is due. Around the boundaries it also samples one edge early, which shows the result is neither early nor late.

// File: rtl/extint_pkg.sv
package extint_pkg;
   localparam int unsigned CTRL_W     = 8;
   localparam int unsigned SEL_BIT    = 7;
   localparam int unsigned ENA_BIT    = 6;
   localparam int unsigned SYNC_DEPTH = 2;

   typedef enum logic {
      SENSE_LEVEL = 1'b0,
      SENSE_FALL  = 1'b1
   } sense_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 2) begin : g_bad_depth
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[i] <= IDLE_LV;
         else if (i == 0)
            chain[i] <= d_in;
         else
            chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/extint_cfg_reg.sv
module extint_cfg_reg #(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned SEL_POS = 7,
   parameter int unsigned ENA_POS = 6,
   parameter logic        ENA_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             special_mode,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic             sel_q,
   output logic             ena_q,
   output logic [REG_W-1:0] rd_data
);
   if (SEL_POS >= REG_W || ENA_POS >= REG_W) begin : g_bad_pos
      $error("extint_cfg_reg: bit position outside register");
   end
   if (SEL_POS == ENA_POS) begin : g_bad_overlap
      $error("extint_cfg_reg: select and enable share a bit");
   end

   logic lock_q;
   logic sel_wr_ok;

   assign sel_wr_ok = wr_en && (special_mode || !lock_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         ena_q  <= ENA_RST;
         lock_q <= 1'b0;
      end else begin
         if (wr_en)
            ena_q <= wr_data[ENA_POS];
         if (sel_wr_ok)
            sel_q <= wr_data[SEL_POS];
         if (wr_en && !special_mode)
            lock_q <= 1'b1;
      end
   end

   for (genvar b = 0; b < REG_W; b++) begin : g_rd
      if (b == SEL_POS) begin : g_sel
         assign rd_data[b] = sel_q;
      end else if (b == ENA_POS) begin : g_ena
         assign rd_data[b] = ena_q;
      end else begin : g_zero
         assign rd_data[b] = 1'b0;
      end
   end

   // R3: once locked, a normal-mode write keeps the select bit
   p_sel_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr_en && !special_mode) |=> $stable(sel_q));
   // R3: the lock never drops without reset
   p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
endmodule

// File: rtl/extint_edge_latch.sv
module extint_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_sync,
   input  logic edge_mode,
   input  logic svc_ack,
   output logic fall_seen,
   output logic pend_q
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= 1'b1;
      else
         prev_q <= lvl_sync;
   end

   assign fall_seen = prev_q && !lvl_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (fall_seen && edge_mode)
         pend_q <= 1'b1;
      else if (svc_ack)
         pend_q <= 1'b0;
   end

   // R5: an edge in edge mode is always stored
   p_fall_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_seen && edge_mode) |=> pend_q);
   // R6: an acknowledge without a new edge clears the latch
   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_ack && !(fall_seen && edge_mode)) |=> !pend_q);
   // R5: pending holds until acknowledged
   p_pend_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !svc_ack) |=> pend_q);
endmodule

// File: rtl/extint_pin_ctrl.sv
module extint_pin_ctrl
   import extint_pkg::*;
#(
   parameter int unsigned REG_W   = CTRL_W,
   parameter int unsigned SEL_POS = SEL_BIT,
   parameter int unsigned ENA_POS = ENA_BIT,
   parameter int unsigned SYNC_N  = SYNC_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             special_mode,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             pin_n,
   input  logic             svc_ack,
   output logic             irq_req
);
   logic   pin_s;
   logic   sel_q;
   logic   ena_q;
   logic   fall_seen;
   logic   pend_q;
   sense_e sense;

   extint_sync #(.STAGES(SYNC_N), .IDLE_LV(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(pin_n), .q_out(pin_s)
   );

   extint_cfg_reg #(
      .REG_W(REG_W), .SEL_POS(SEL_POS), .ENA_POS(ENA_POS), .ENA_RST(1'b1)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .wr_en(wr_en), .wr_data(wr_data),
      .sel_q(sel_q), .ena_q(ena_q), .rd_data(rd_data)
   );

   assign sense = sense_e'(sel_q);

   extint_edge_latch u_latch (
      .clk(clk), .rst_n(rst_n), .lvl_sync(pin_s),
      .edge_mode(sense == SENSE_FALL), .svc_ack(svc_ack),
      .fall_seen(fall_seen), .pend_q(pend_q)
   );

   always_comb begin
      unique case (sense)
         SENSE_LEVEL: irq_req = ena_q && !pin_s;
         SENSE_FALL:  irq_req = ena_q && pend_q;
         default:     irq_req = 1'b0;
      endcase
   end

   // R2: a disabled pin never raises a request
   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[ENA_POS] |-> !irq_req);
endmodule

// File: tb/tb_extint_pin_ctrl.sv
module tb_extint_pin_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       special_mode = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       pin_n = 1'b1;
   logic       svc_ack = 1'b0;
   logic       irq_req;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   extint_pin_ctrl dut (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .pin_n(pin_n), .svc_ack(svc_ack), .irq_req(irq_req)
   );

   // {special, write data, expected read-back}
   localparam logic [16:0] VEC [9] = '{
      {1'b0, 8'h80, 8'h80},   // R3 first normal write loads select
      {1'b0, 8'h00, 8'h80},   // R3 locked select, enable cleared
      {1'b0, 8'h40, 8'hC0},   // R2 enable set again
      {1'b0, 8'h3F, 8'h80},   // R7 low bits ignored
      {1'b0, 8'h7F, 8'hC0},   // R7
      {1'b1, 8'h00, 8'h00},   // R4 special mode changes select
      {1'b1, 8'hFF, 8'hC0},   // R4
      {1'b1, 8'h40, 8'h40},   // R4
      {1'b0, 8'h80, 8'h00}    // R3 lock survives special writes
   };

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
   endtask

   task automatic wr(logic spec, logic [7:0] d);
      special_mode = spec;
      wr_en = 1'b1;
      wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   initial begin
      #1000000;
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      chk("R8 reset rd", rd_data, 8'h40);
      chk("R8 reset irq", {7'b0, irq_req}, 8'h00);

      for (int k = 0; k < 9; k++) begin
         wr(VEC[k][16], VEC[k][15:8]);
         chk($sformatf("R3/R4/R7 vec%0d", k), rd_data, VEC[k][7:0]);
      end

      // R8: reset clears the lock
      do_reset();
      wr(1'b0, 8'hC0);
      chk("R8 lock cleared by reset", rd_data, 8'hC0);

      // R1 level mode
      do_reset();
      pin_n = 1'b0;
      step(1);
      chk("R1 level one edge early", {7'b0, irq_req}, 8'h00);
      step(1);
      chk("R1 level due", {7'b0, irq_req}, 8'h01);
      wr(1'b0, 8'h00);
      chk("R2 level disabled", {7'b0, irq_req}, 8'h00);
      wr(1'b0, 8'h40);
      chk("R2 level re-enabled", {7'b0, irq_req}, 8'h01);
      pin_n = 1'b1;
      step(1);
      chk("R1 release early", {7'b0, irq_req}, 8'h01);
      step(1);
      chk("R1 release due", {7'b0, irq_req}, 8'h00);

      // R9: fall in level mode, then switch to edge mode
      pin_n = 1'b0; step(3); pin_n = 1'b1; step(3);
      wr(1'b1, 8'hC0);
      chk("R9 no stored edge", {7'b0, irq_req}, 8'h00);

      // R5 edge mode
      pin_n = 1'b0;
      step(2);
      chk("R5 edge early", {7'b0, irq_req}, 8'h00);
      step(1);
      chk("R5 edge due", {7'b0, irq_req}, 8'h01);
      pin_n = 1'b1;
      step(3);
      chk("R5 held after release", {7'b0, irq_req}, 8'h01);

      // R6 ack together with new edge keeps the latch
      pin_n = 1'b0;
      step(2);
      svc_ack = 1'b1;
      step(1);
      svc_ack = 1'b0;
      chk("R6 ack with edge", {7'b0, irq_req}, 8'h01);
      svc_ack = 1'b1;
      step(1);
      svc_ack = 1'b0;
      chk("R6 ack clears", {7'b0, irq_req}, 8'h00);
      step(3);
      chk("R6 steady low no edge", {7'b0, irq_req}, 8'h00);

      // R5 edge captured while disabled
      pin_n = 1'b1; step(3);
      wr(1'b1, 8'h80);
      pin_n = 1'b0; step(3);
      chk("R2 edge disabled", {7'b0, irq_req}, 8'h00);
      wr(1'b1, 8'hC0);
      chk("R5 edge kept while disabled", {7'b0, irq_req}, 8'h01);

      // R8 reset clears the latch
      do_reset();
      chk("R8 latch cleared", {7'b0, irq_req}, 8'h00);
      chk("R8 rd after reset", rd_data, 8'h40);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule